// File: doc/BRIEF.md
# Runahead Branch Outcome Recorder

While a core pre-executes past a long cache miss, every conditional branch it meets is resolved or assumed resolved. This block keeps those directions in a small shift-register queue, in execution order. When the miss has been serviced and the core rolls back to its checkpoint and re-executes the same path, the block hands the stored directions back one per branch, oldest first, as predictions that are usually very accurate.

A branch whose operands depend on the missing data cannot be resolved during pre-execution. Such a branch is treated as if its prediction had been right, so the predicted direction is stored in its place. The replayed directions are only a hint. When the queue is empty, or after the pipeline signals a misprediction, the hit flag drops and the surrounding baseline predictor takes over. The queue is emptied each time pre-execution starts. Once it is full, further outcomes are dropped.

Top module: `rabr_recorder`

## Requirements
- R1: While `ra_mode` is 1, each cycle with `rec_valid` = 1 appends one direction to the tail of the queue. The stored direction is `rec_taken` when `rec_inv` = 0 and `rec_pred` when `rec_inv` = 1.
- R2: While `ra_mode` is 0, `rec_valid` has no effect. No direction is added, so the replay sequence is unchanged.
- R3: The queue holds `DEPTH` directions. A record that arrives while the queue is full is dropped, and the earlier entries are kept.
- R4: In the first cycle of runahead (`ra_mode` 1 after 0 on the previous clock), all earlier contents are discarded. A record in that same cycle becomes the oldest entry.
- R5: While `ra_mode` is 1, `pred_hit` is 0 and the queue is not popped.
- R6: While `ra_mode` is 0, a cycle with `pred_req` = 1, a non-empty queue and `mispredict` = 0 sets `pred_hit` = 1 in the same cycle. `pred_taken` then equals the oldest stored direction, and that entry is removed on the clock edge. Successive requests therefore return directions in recording order.
- R7: When `pred_hit` is 0, `pred_taken` is 0. With an empty queue, a request gives `pred_hit` = 0.
- R8: `mispredict` = 1 while `ra_mode` is 0 forces `pred_hit` to 0 in that cycle and empties the queue. `mispredict` while `ra_mode` is 1 has no effect.
- R9: After reset the queue is empty and the block is in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_mode | input | 1 | 1 while the core pre-executes under a miss |
| rec_valid | input | 1 | A conditional branch outcome is offered this cycle |
| rec_taken | input | 1 | Computed direction (1 = taken) |
| rec_inv | input | 1 | Branch sources were invalid, so the direction is unresolved |
| rec_pred | input | 1 | Direction the branch was predicted with |
| pred_req | input | 1 | A branch in normal mode asks for a prediction |
| mispredict | input | 1 | A branch misprediction was detected in normal mode |
| pred_hit | output | 1 | A recorded direction is supplied this cycle |
| pred_taken | output | 1 | Supplied direction, 0 when no hit |

## Verification
The bench fills the queue past capacity and replays it. A design with an off-by-one on the full test would either lose the last slot or corrupt the order with an extra entry. It re-enters runahead while stale entries remain and records on the entry cycle itself. Failing to clear would replay old directions, and clearing after the push would lose the first new one. It also mixes unresolved and resolved branches to catch a selector that is inverted. Finally it signals a misprediction during a request and during runahead, which exposes a flush that leaks a hit or fires in the wrong mode.

// File: rtl/rabr_pkg.sv
// Shared types and helpers for the runahead branch outcome recorder.
// Assumes one branch record per cycle at most.
package rabr_pkg;

    // One offered branch outcome.
    typedef struct packed {
        logic taken;
        logic inv;
        logic pred;
    } rabr_rec_t;

    // Direction to keep: the prediction stands in for an unresolved branch.
    function automatic logic rabr_resolve(rabr_rec_t r);
        return r.inv ? r.pred : r.taken;
    endfunction

endpackage

// File: rtl/rabr_mode_track.sv
// Mode tracker: flags the first cycle of runahead.
// Assumes ra_mode is a registered, glitch-free level from the pipeline.
module rabr_mode_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ra_mode,
    output logic entry
);
    logic mode_q;

    // Remember the previous cycle's mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= ra_mode;
    end

    // Entry is the rising edge of the mode level.
    always_comb entry = ra_mode & ~mode_q;
endmodule

// File: rtl/rabr_shift_queue.sv
// Shift-register queue of single-bit directions.
// Push writes at the fill index. Pop shifts every slot one place toward
// slot 0, which is always the oldest entry. Clear restarts the fill at zero
// in the same cycle as a push. Flush empties the queue. Assumes push and pop
// never coincide and that pop is only requested when the queue is not empty.
module rabr_shift_queue #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          flush,
    input  logic          push,
    input  logic          din,
    input  logic          pop,
    output logic          head,
    output logic          empty,
    output logic [CW-1:0] fill
);
    logic [DEPTH-1:0] slot_q;
    logic [CW-1:0]    base;
    logic             accept;

    // Fill level seen by this cycle's push, after any clear.
    always_comb begin
        base   = clear ? '0 : fill;
        accept = push && (base < CW'(DEPTH));
    end

    // Per-slot storage: write at the tail, otherwise shift down on pop.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (!rst_n)                         slot_q[i] <= 1'b0;
                else if (accept && base == CW'(i))  slot_q[i] <= din;
                else if (pop)                       slot_q[i] <= 1'b0;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (!rst_n)                         slot_q[i] <= 1'b0;
                else if (accept && base == CW'(i))  slot_q[i] <= din;
                else if (pop)                       slot_q[i] <= slot_q[i+1];
            end
        end
    end

    // Fill counter: flush, then push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      fill <= '0;
        else if (flush)  fill <= '0;
        else if (accept) fill <= base + 1'b1;
        else if (clear)  fill <= '0;
        else if (pop)    fill <= fill - 1'b1;
    end

    // Oldest entry and empty flag.
    always_comb begin
        head  = slot_q[0];
        empty = (fill == '0);
    end
endmodule

// File: rtl/rabr_recorder.sv
// Runahead branch outcome recorder (top).
// Records branch directions during runahead and replays them in order as
// predictions after the return to normal mode. The output is a hint only.
// Assumes a synchronous active-low reset and at most one record or one
// request per cycle.
module rabr_recorder #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ra_mode,
    input  logic rec_valid,
    input  logic rec_taken,
    input  logic rec_inv,
    input  logic rec_pred,
    input  logic pred_req,
    input  logic mispredict,
    output logic pred_hit,
    output logic pred_taken
);
    import rabr_pkg::*;

    logic      entry;
    logic      head;
    logic      empty;
    logic      push;
    logic      pop;
    logic      flush;
    logic      dir;
    rabr_rec_t rec;
    logic [CW-1:0] fill;

    rabr_mode_track u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_mode (ra_mode),
        .entry   (entry)
    );

    // Choose the direction to keep and qualify the record by mode.
    always_comb begin
        rec   = '{taken: rec_taken, inv: rec_inv, pred: rec_pred};
        dir   = rabr_resolve(rec);
        push  = ra_mode & rec_valid;
        flush = ~ra_mode & mispredict;
    end

    // Serve a normal-mode request from the head of the queue.
    always_comb begin
        pred_hit   = ~ra_mode & pred_req & ~mispredict & ~empty;
        pred_taken = pred_hit & head;
        pop        = pred_hit;
    end

    rabr_shift_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (entry),
        .flush (flush),
        .push  (push),
        .din   (dir),
        .pop   (pop),
        .head  (head),
        .empty (empty),
        .fill  (fill)
    );
endmodule

// File: rtl/rabr_checker.sv
// Checker for rabr_recorder, bound to every instance of it.
// Relates the mode, the request port and the internal fill level over time.
module rabr_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ra_mode,
    input logic          pred_req,
    input logic          mispredict,
    input logic          pred_hit,
    input logic          pred_taken,
    input logic [CW-1:0] fill
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH)); // R3
    AST_NORMAL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n) !ra_mode |=> fill <= $past(fill)); // R2
    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $rose(ra_mode) |=> fill <= CW'(1)); // R4
    AST_RA_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) ra_mode |-> !pred_hit); // R5
    AST_HIT_POPS: assert property (@(posedge clk) disable iff (!rst_n) pred_hit |=> fill == $past(fill) - 1'b1); // R6
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) pred_hit |-> pred_req); // R6
    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) !pred_hit |-> !pred_taken); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (!ra_mode && mispredict) |=> fill == '0); // R8
    AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) mispredict |-> !pred_hit); // R8
endmodule

bind rabr_recorder rabr_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_mode    (ra_mode),
    .pred_req   (pred_req),
    .mispredict (mispredict),
    .pred_hit   (pred_hit),
    .pred_taken (pred_taken),
    .fill       (fill)
);

// File: tb/sim_rabr_recorder.sv
// Bench for rabr_recorder: a vector table, then directed corner tests.
module sim_rabr_recorder;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ra_mode = 1'b0, rec_valid = 1'b0, rec_taken = 1'b0, rec_inv = 1'b0;
    logic rec_pred = 1'b0, pred_req = 1'b0, mispredict = 1'b0;
    logic pred_hit, pred_taken;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rabr_recorder #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ra_mode(ra_mode), .rec_valid(rec_valid),
        .rec_taken(rec_taken), .rec_inv(rec_inv), .rec_pred(rec_pred),
        .pred_req(pred_req), .mispredict(mispredict),
        .pred_hit(pred_hit), .pred_taken(pred_taken)
    );

    // Row fields: [12:9] requirement, [8] ra_mode, [7] rec_valid, [6] rec_taken,
    // [5] rec_inv, [4] rec_pred, [3] pred_req, [2] mispredict, [1] hit, [0] taken
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {4'd7, 9'b0_0000_1_0_00},  // empty after reset: miss
        {4'd1, 9'b1_1100_0_0_00},  // taken, resolved
        {4'd1, 9'b1_1110_0_0_00},  // unresolved, predicted not taken
        {4'd1, 9'b1_1000_0_0_00},  // not taken, resolved
        {4'd1, 9'b1_1011_0_0_00},  // unresolved, predicted taken
        {4'd5, 9'b1_0000_1_0_00},  // request in runahead: no hit
        {4'd6, 9'b0_1100_1_0_11},  // replay 1 (record ignored, R2)
        {4'd6, 9'b0_0000_1_0_10},
        {4'd6, 9'b0_0000_1_0_10},
        {4'd6, 9'b0_0000_1_0_11},
        {4'd2, 9'b0_0000_1_0_00},  // normal-mode record was not added
        {4'd7, 9'b0_0000_0_0_00}   // no request: no hit
    };

    task automatic drive(input logic ra, rv, rt, ri, rp, rq, mp);
        @(negedge clk);
        ra_mode = ra; rec_valid = rv; rec_taken = rt; rec_inv = ri;
        rec_pred = rp; pred_req = rq; mispredict = mp;
        #5;
    endtask

    task automatic check(input string req, input logic eh, input logic et);
        checks++;
        if (pred_hit !== eh || pred_taken !== et) begin
            errors++;
            $display("FAIL %s: hit/taken = %b/%b, expected %b/%b", req, pred_hit, pred_taken, eh, et);
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R9: outputs after reset with a request pending
        drive(0, 0, 0, 0, 0, 1, 0);
        rst_n = 1'b1;
        check("R9", 1'b0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
            check($sformatf("R%0d", VEC[v][12:9]), VEC[v][1], VEC[v][0]);
        end

        // R3: overfill by two, replay DEPTH entries in order, then empty
        for (int i = 0; i < DEPTH + 2; i++) drive(1, 1, (i % 3 == 0), 0, 0, 0, 0);
        for (int i = 0; i < DEPTH; i++) begin
            drive(0, 0, 0, 0, 0, 1, 0);
            check("R3", 1'b1, (i % 3 == 0));
        end
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R3", 1'b0, 1'b0);

        // R4: stale entries dropped on re-entry; entry-cycle record kept
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R4", 1'b1, 1'b0);
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R4", 1'b1, 1'b1);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R4", 1'b0, 1'b0);

        // R8: mispredict with a request gives no hit and empties the queue
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8", 1'b1, 1'b1);
        drive(0, 0, 0, 0, 0, 1, 1);
        check("R8", 1'b0, 1'b0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8", 1'b0, 1'b0);

        // R8: mispredict during runahead is ignored
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 1);
        drive(1, 1, 1, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8", 1'b1, 1'b1);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8", 1'b1, 1'b0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R8", 1'b1, 1'b1);

        // R1: direction choice under the same taken value, opposite prediction
        drive(1, 1, 0, 1, 1, 0, 0);
        drive(1, 1, 1, 1, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R1", 1'b1, 1'b1);
        drive(0, 0, 0, 0, 0, 1, 0);
        check("R1", 1'b1, 1'b0);

        drive(0, 0, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule